// File: doc/BRIEF.md
# Paged Serial Flash Geometry Detector

After a start pulse this block works out what kind of paged serial flash sits on its SPI port and reports the geometry: the number of pages, the bytes per page, the address shift that places a page number above the byte offset, and whether a supported part was found at all. It does not move bytes on the wire itself. It drives a byte-level SPI engine through a request/acknowledge pair and controls chip select directly.

Detection has two stages. The first frame sends the identification opcode and collects five identification bytes. If the first byte carries the expected manufacturer code, the bytes are looked up in a small built-in table. The five-byte extended identity is tried first, then the three-byte identity. Parts that can run either a power-of-two or a slightly larger page then need a status read, and bit 0 of the status byte picks between the two sizes. If the manufacturer byte is anything else, the block reads the status byte and decodes a density code from it instead. Chip select is released for a programmable number of cycles between the two frames.

Top module: `flash_geom_probe`

## Requirements
- R1: A start pulse in idle opens one chip-select-low frame of exactly six byte exchanges: opcode 0x9F, then five bytes of 0x00. The bytes received on exchanges two to six are the identity, most significant (manufacturer) byte first.
- R2: When a status byte is needed, chip select stays high for at least GAP_CYCLES clock cycles after the identity frame. A second frame then sends 0xD7 followed by 0x00, and the byte received on the second exchange is the status byte.
- R3: Manufacturer 0x1F with the full identity 1F 28 00 01 00 gives 32768 pages with the binary page option. Any other fifth or fourth byte falls through to the three-byte lookup.
- R4: The three-byte identities 1F2200, 1F2400, 1F2600, 1F2701 and 1F2800 give 512, 2048, 4096, 8192 and 8192 pages, with base page sizes of 256, 256, 512, 512 and 1024 bytes respectively. All of them have the binary page option.
- R5: For a part with the binary page option, status bit 0 = 1 selects the base size B (a power of two) with shift log2(B). Bit 0 = 0 selects B + B/32 bytes with shift log2(B)+1.
- R6: Identity 1F2700 has no binary option. It reports 8192 pages of 528 bytes with shift 10, and no status frame is issued.
- R7: Manufacturer 0x1F with no table match reports not found and issues no status frame.
- R8: When the manufacturer byte is not 0x1F, the status byte is read. A status of 0x00 or 0xFF reports not found.
- R9: The fallback decodes status AND 0x3C. 0x0C, 0x14, 0x1C and 0x24 give 512, 1024, 2048 and 4096 pages of 264 bytes with shift 9. 0x2C and 0x34 give 4096 and 8192 pages of 528 bytes with shift 10. 0x38 and 0x3C give 8192 pages of 1056 bytes with shift 11. Status bit 0 has no effect here.
- R10: Every other fallback density code reports not found.
- R11: done is a one-cycle pulse. The geometry outputs take new values only in the cycle done is high and otherwise hold, including during the next detection. When nothing is found, page count, page size and shift are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin detection (taken only while idle) |
| done | output | 1 | One-cycle pulse; geometry valid |
| cs_n | output | 1 | Flash chip select, active low |
| xfer_req | output | 1 | Request one byte exchange, held until acknowledged |
| xfer_tx | output | 8 | Byte to shift out |
| xfer_ack | input | 1 | One-cycle pulse: exchange finished, xfer_rx valid |
| xfer_rx | input | 8 | Byte shifted in |
| found | output | 1 | A supported part was identified |
| page_count | output | 16 | Number of pages |
| page_bytes | output | 11 | Bytes per page |
| addr_shift | output | 4 | Bit position of the page number in a flash address |

## Verification
The assertions take it for granted that the byte engine pulses xfer_ack only for one cycle while a request is outstanding, and so never while chip select is high. They also assume GAP_CYCLES is at least two, so that a rising chip select is always followed by another high cycle. The bench's engine model waits for a request, returns its answer two cycles later as a single acknowledge pulse, and goes quiet as soon as the request drops. Its answers come from the identity and status scripted for each case.

// File: rtl/flash_geom_probe.sv
module flash_geom_probe #(
  parameter int GAP_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output logic        done,
  output logic        cs_n,
  output logic        xfer_req,
  output logic [7:0]  xfer_tx,
  input  logic        xfer_ack,
  input  logic [7:0]  xfer_rx,
  output logic        found,
  output logic [15:0] page_count,
  output logic [10:0] page_bytes,
  output logic [3:0]  addr_shift
);
  localparam int GW = $clog2(GAP_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_ID, S_GAP, S_STAT, S_EVAL, S_FIN} state_t;
  state_t state;
  logic [39:0] id_q;
  logic [7:0]  stat_q;
  logic [2:0]  cnt;
  logic [GW-1:0] gcnt;

  assign xfer_req = (state == S_ID) || (state == S_STAT);
  assign cs_n     = !xfer_req;
  assign xfer_tx  = (cnt != 3'd0) ? 8'h00 : ((state == S_STAT) ? 8'hD7 : 8'h9F);
  assign done     = (state == S_FIN);

  logic        mfr_ok, hit, binopt;
  logic [15:0] t_pages;
  logic [3:0]  t_s;
  assign mfr_ok = (id_q[39:32] == 8'h1F);

  always_comb begin
    hit = 1'b1; binopt = 1'b1; t_pages = 16'd0; t_s = 4'd8;
    if (id_q == 40'h1F28000100) t_pages = 16'd32768;
    else begin
      case (id_q[39:16])
        24'h1F2200: t_pages = 16'd512;
        24'h1F2400: t_pages = 16'd2048;
        24'h1F2600: begin t_pages = 16'd4096; t_s = 4'd9; end
        24'h1F2700: begin t_pages = 16'd8192; t_s = 4'd9; binopt = 1'b0; end
        24'h1F2701: begin t_pages = 16'd8192; t_s = 4'd9; end
        24'h1F2800: begin t_pages = 16'd8192; t_s = 4'd10; end
        default:    hit = 1'b0;
      endcase
    end
  end

  logic        fb_ok;
  logic [15:0] fb_pages;
  logic [3:0]  fb_s;
  always_comb begin
    fb_ok = 1'b1; fb_pages = 16'd0; fb_s = 4'd8;
    case (stat_q & 8'h3C)
      8'h0C: fb_pages = 16'd512;
      8'h14: fb_pages = 16'd1024;
      8'h1C: fb_pages = 16'd2048;
      8'h24: fb_pages = 16'd4096;
      8'h2C: begin fb_pages = 16'd4096; fb_s = 4'd9; end
      8'h34: begin fb_pages = 16'd8192; fb_s = 4'd9; end
      8'h38, 8'h3C: begin fb_pages = 16'd8192; fb_s = 4'd10; end
      default: fb_ok = 1'b0;
    endcase
    if (stat_q == 8'h00 || stat_q == 8'hFF) fb_ok = 1'b0;
  end

  logic        r_found, r_bin;
  logic [15:0] r_pages;
  logic [3:0]  r_s;
  assign r_found = mfr_ok ? hit : fb_ok;
  assign r_pages = mfr_ok ? t_pages : fb_pages;
  assign r_s     = mfr_ok ? t_s : fb_s;
  assign r_bin   = mfr_ok && binopt && stat_q[0];

  wire need_status = !mfr_ok || (hit && binopt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE; id_q <= '0; stat_q <= '0; cnt <= '0; gcnt <= '0;
      found <= 1'b0; page_count <= '0; page_bytes <= '0; addr_shift <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin state <= S_ID; cnt <= '0; end
        S_ID: if (xfer_ack) begin
          if (cnt != 3'd0) id_q <= {id_q[31:0], xfer_rx};
          if (cnt == 3'd5) begin state <= S_GAP; gcnt <= '0; end
          else cnt <= cnt + 3'd1;
        end
        S_GAP: begin
          if (gcnt == GW'(GAP_CYCLES - 1)) begin
            state <= need_status ? S_STAT : S_EVAL;
            cnt   <= '0;
          end else gcnt <= gcnt + 1'b1;
        end
        S_STAT: if (xfer_ack) begin
          if (cnt == 3'd1) begin stat_q <= xfer_rx; state <= S_EVAL; end
          else cnt <= cnt + 3'd1;
        end
        S_EVAL: begin
          state      <= S_FIN;
          found      <= r_found;
          page_count <= r_found ? r_pages : 16'd0;
          page_bytes <= !r_found ? 11'd0 :
                        r_bin ? (11'd1 << r_s) : ((11'd1 << r_s) + (11'd1 << (r_s - 4'd5)));
          addr_shift <= !r_found ? 4'd0 : (r_bin ? r_s : r_s + 4'd1);
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_ack_in_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ack |-> !cs_n);
  assert_cs_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> cs_n);
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(found) && $stable(page_count) && $stable(page_bytes) && $stable(addr_shift)));
  assert_clear_when_absent_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !found |-> (page_count == 16'd0 && page_bytes == 11'd0 && addr_shift == 4'd0));
  assert_size_fits_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> ({1'b0, page_bytes} <= (12'd1 << addr_shift) &&
               {1'b0, page_bytes} >  (12'd1 << (addr_shift - 4'd1))));
endmodule

// File: tb/flash_geom_probe_bench.sv
module flash_geom_probe_bench;
  localparam int GAP = 4;
  localparam int NV  = 28;
  localparam logic [95:0] VEC [NV] = '{
    {40'h1F22000000, 8'h01, 16'd512,   16'd256,  8'd8,  8'h3},
    {40'h1F22000000, 8'h00, 16'd512,   16'd264,  8'd9,  8'h3},
    {40'h1F24000000, 8'h01, 16'd2048,  16'd256,  8'd8,  8'h3},
    {40'h1F24000000, 8'h00, 16'd2048,  16'd264,  8'd9,  8'h3},
    {40'h1F26000000, 8'h00, 16'd4096,  16'd528,  8'd10, 8'h3},
    {40'h1F26000000, 8'h01, 16'd4096,  16'd512,  8'd9,  8'h3},
    {40'h1F27000000, 8'h81, 16'd8192,  16'd528,  8'd10, 8'h2},
    {40'h1F27010000, 8'h01, 16'd8192,  16'd512,  8'd9,  8'h3},
    {40'h1F28000000, 8'h00, 16'd8192,  16'd1056, 8'd11, 8'h3},
    {40'h1F28000000, 8'h01, 16'd8192,  16'd1024, 8'd10, 8'h3},
    {40'h1F28000100, 8'h01, 16'd32768, 16'd256,  8'd8,  8'h3},
    {40'h1F28000100, 8'h00, 16'd32768, 16'd264,  8'd9,  8'h3},
    {40'h1F99000000, 8'h01, 16'd0,     16'd0,    8'd0,  8'h0},
    {40'h1F28000101, 8'h01, 16'd8192,  16'd1024, 8'd10, 8'h3},
    {40'hFFFFFFFFFF, 8'h8C, 16'd512,   16'd264,  8'd9,  8'h3},
    {40'hFFFFFFFFFF, 8'h94, 16'd1024,  16'd264,  8'd9,  8'h3},
    {40'hFFFFFFFFFF, 8'h9C, 16'd2048,  16'd264,  8'd9,  8'h3},
    {40'hFFFFFFFFFF, 8'hA4, 16'd4096,  16'd264,  8'd9,  8'h3},
    {40'hFFFFFFFFFF, 8'hAC, 16'd4096,  16'd528,  8'd10, 8'h3},
    {40'hFFFFFFFFFF, 8'hB4, 16'd8192,  16'd528,  8'd10, 8'h3},
    {40'hFFFFFFFFFF, 8'hB8, 16'd8192,  16'd1056, 8'd11, 8'h3},
    {40'h0000000000, 8'hBC, 16'd8192,  16'd1056, 8'd11, 8'h3},
    {40'hFFFFFFFFFF, 8'h8D, 16'd512,   16'd264,  8'd9,  8'h3},
    {40'h0000000000, 8'h2C, 16'd4096,  16'd528,  8'd10, 8'h3},
    {40'hFFFFFFFFFF, 8'h00, 16'd0,     16'd0,    8'd0,  8'h1},
    {40'hFFFFFFFFFF, 8'hFF, 16'd0,     16'd0,    8'd0,  8'h1},
    {40'hFFFFFFFFFF, 8'h90, 16'd0,     16'd0,    8'd0,  8'h1},
    {40'hFFFFFFFFFF, 8'h80, 16'd0,     16'd0,    8'd0,  8'h1}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic done, cs_n, xfer_req, xfer_ack, found;
  logic [7:0] xfer_tx, xfer_rx;
  logic [15:0] page_count;
  logic [10:0] page_bytes;
  logic [3:0] addr_shift;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  flash_geom_probe #(.GAP_CYCLES(GAP)) u_flash_geom_probe (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .cs_n(cs_n),
    .xfer_req(xfer_req), .xfer_tx(xfer_tx), .xfer_ack(xfer_ack), .xfer_rx(xfer_rx),
    .found(found), .page_count(page_count), .page_bytes(page_bytes), .addr_shift(addr_shift));

  logic [39:0] id_b = '0;
  logic [7:0]  st_b = '0;
  int pos = 0, id_len = 0, st_len = 0, st_frames = 0, bad_tx = 0;
  int high_run = 0, last_gap = 0;
  logic [7:0] op = 8'h00;

  initial begin
    xfer_ack = 1'b0; xfer_rx = 8'h00;
    forever begin
      @(negedge clk);
      xfer_ack = 1'b0;
      if (cs_n) begin pos = 0; high_run++; end
      else if (high_run != 0) begin last_gap = high_run; high_run = 0; end
      if (xfer_req && !cs_n) begin
        logic [7:0] rv;
        if (pos == 0) begin
          op = xfer_tx;
          if (op == 8'hD7) st_frames++;
        end else if (xfer_tx != 8'h00) bad_tx++;
        rv = 8'h00;
        if (op == 8'h9F && pos >= 1 && pos <= 5) rv = id_b[39 - 8*(pos-1) -: 8];
        if (op == 8'hD7 && pos == 1) rv = st_b;
        if (op == 8'h9F) id_len++;
        else if (op == 8'hD7) st_len++;
        else bad_tx++;
        pos++;
        repeat (2) @(negedge clk);
        xfer_rx = rv; xfer_ack = 1'b1;
      end
    end
  end

  task automatic chk(input string tag, input logic [39:0] act, input logic [39:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] outs();
    return {found, page_count, page_bytes, addr_shift};
  endfunction

  logic [31:0] prev = '0;

  task automatic probe(input logic [95:0] v);
    string tag;
    int n, hold_bad;
    logic stf, fnd;
    id_b = v[95:56]; st_b = v[55:48];
    fnd = v[1]; stf = v[0];
    if (id_b[39:32] == 8'h1F) begin
      if (id_b == 40'h1F28000100) tag = "R3";
      else if (id_b[39:16] == 24'h1F2700) tag = "R6";
      else if (fnd) tag = "R4";
      else tag = "R7";
    end else if (fnd) tag = "R9";
    else if (st_b == 8'h00 || st_b == 8'hFF) tag = "R8";
    else tag = "R10";
    @(negedge clk);
    id_len = 0; st_len = 0; st_frames = 0; bad_tx = 0; hold_bad = 0; last_gap = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 5000) begin
      if (outs() !== prev) hold_bad++;
      @(negedge clk);
      n++;
    end
    chk({tag, " found"}, found, fnd);
    chk({tag, " pages"}, page_count, v[47:32]);
    chk({(id_b[39:32] == 8'h1F && fnd) ? "R5 " : "", tag, " bytes"}, page_bytes, v[26:16]);
    chk({(id_b[39:32] == 8'h1F && fnd) ? "R5 " : "", tag, " shift"}, addr_shift, v[11:8]);
    chk("R1 id frame length", id_len, 6);
    chk("R1 filler bytes", bad_tx, 0);
    chk({tag, " R2 status frames"}, st_frames, stf);
    if (stf) begin
      chk("R2 status frame length", st_len, 2);
      chk("R2 cs gap", last_gap >= GAP, 1);
    end
    chk("R11 hold during detection", hold_bad, 0);
    prev = outs();
    @(negedge clk);
    chk("R11 done pulse", done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R11 act=no_done exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset found", found, 0);
    chk("R11 reset outputs", {page_count, page_bytes, addr_shift}, 0);
    chk("R11 reset done", done, 0);
    chk("R1 reset cs_n", cs_n, 1);
    chk("R1 reset req", xfer_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) probe(VEC[i]);
    probe(VEC[10]);
    repeat (20) @(negedge clk);
    chk("R11 outputs held after done", outs(), prev);
    chk("R11 done stays low", done, 0);
    chk("R1 idle cs_n", cs_n, 1);
    probe(VEC[12]);
    probe(VEC[0]);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule